// File: doc/BRIEF.md
# Cartridge Bank Mapper Controller

This block sits between the console's CPU bus and the cartridge hardware. Writes into the lower 16 KiB of the ROM area never reach memory. They load a small file of one-byte registers: a 16-bit ROM bank number, an SRAM bank number and a command byte. The block drives the upper address bits for the switchable ROM window and the SRAM bank bits. It also chooses what answers in the 8 KiB external window: a read-only copy of the mapper registers, SRAM (read-only or read/write), or the clock latch registers.

The command byte has three jobs. It selects the external window mapping. It issues one-cycle strobes to an external real-time clock. It sets a rumble motor speed, which is clamped to what the cartridge can do. Writes into the switchable ROM window are passed on to the ROM as a write strobe with the full banked address, which flash-style hardware can use. The clock counters, the memories and the motor driver are outside this block. Command values that are not recognised are ignored and leave a sticky flag raised.

Top module: `cart_mapper`

## Requirements
- R1: A write (`wr`=1) with `addr[15:14]`=0 updates exactly one register, chosen by `addr[1:0]`: 0 = ROM bank low byte, 1 = ROM bank high byte, 2 = SRAM bank, 3 = command. All other address bits are ignored. The register takes the new value at the clock edge that samples the write.
- R2: `rom_bank` equals {high byte, low byte} with no remapping. Writing zero to both bytes gives bank 0.
- R3: All 8 bits of the ROM low, ROM high and SRAM bank registers are kept. When the register mapping is active, a read (`rd`=1) at an address in 0xA000-0xBFFF returns ROM low, ROM high, SRAM bank or status for `addr[1:0]` = 0, 1, 2, 3, and this repeats every 4 bytes.
- R4: The status byte is {4'b1111, `rtc_ovf_i`, `rtc_running_i`, rumble speed[1:0]}, from bit 7 down to bit 0.
- R5: `win_sel` gives the window mapping: 0 = registers (command 0x00), 1 = SRAM read-only (0x02), 2 = SRAM read/write (0x03), 3 = clock latches (0x05). A window write raises `sram_we` only in mode 2 and `rtc_we` only in mode 3. In mode 0 a window write changes no register.
- R6: Commands 0x10, 0x11, 0x14, 0x18 and 0x19 each raise a single bit of `rtc_cmd` for exactly one cycle, the cycle after the command write. The bits are 0 latch, 1 set, 2 clear overflow, 3 stop, 4 start. These commands leave `win_sel` unchanged.
- R7: Commands 0x20-0x23 request rumble speed 0-3. The stored speed is the request clamped to the cartridge's capability. With multiple speeds it is unchanged. With a single speed, any request from 1 to 3 gives 1. With no rumble it is always 0.
- R8: Reset gives ROM bank 0x0001, SRAM bank 0x00, `win_sel`=0, rumble speed 0, `cmd_invalid`=0 and `rtc_cmd`=0.
- R9: A command value outside the recognised list changes neither the window mapping nor the rumble speed and raises no clock strobe. It sets `cmd_invalid`, which stays set until reset.
- R10: A write with `addr[15:14]`=1 raises `rom_we` in the same cycle. `rom_waddr` = {`rom_bank`, `addr[13:0]`}. No mapper register changes.
- R11: `rdata` is 0xFF unless `rd`=1, the address is in 0xA000-0xBFFF and the register mapping is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe |
| rtc_running_i | input | 1 | Clock-running flag from the external clock |
| rtc_ovf_i | input | 1 | Week-overflow flag from the external clock |
| rdata | output | 8 | Register mirror read data (0xFF when not selected) |
| rom_bank | output | 16 | Bank number for the switchable ROM window |
| rom_we | output | 1 | Write strobe forwarded to the ROM |
| rom_waddr | output | 30 | Full banked ROM address for forwarded writes |
| sram_bank | output | 8 | SRAM bank number |
| sram_we | output | 1 | SRAM write enable |
| rtc_we | output | 1 | Clock latch register write enable |
| win_sel | output | 2 | External window source |
| rtc_cmd | output | 5 | One-cycle clock command strobes |
| rumble_speed | output | 2 | Clamped rumble speed |
| cmd_invalid | output | 1 | Sticky flag for an unrecognised command |

## Verification
On every cycle the assertions check several things. Each register write lands in the byte its address selects. The clock strobes stay one-hot and follow a command write. Forwarded ROM writes leave the banks alone. The write enables never fire outside their window mode. The clamp ceiling holds for the configured rumble capability. The invalid flag never drops. Other behaviour can only be shown by the bench's scenarios: the value of each read through the 4-byte mirror, the exact status byte, the banked ROM address, and the different clamp results of three instances built with different rumble capability.

// File: rtl/cart_mapper_pkg.sv
// Package: shared types and command helpers for the cartridge bank mapper.
// Assumes 8-bit command codes; the functions are pure and synthesizable.
package cart_mapper_pkg;

    typedef enum logic [1:0] {
        WIN_REGS    = 2'd0,
        WIN_SRAM_RO = 2'd1,
        WIN_SRAM_RW = 2'd2,
        WIN_RTC     = 2'd3
    } win_sel_e;

    localparam int RTC_CMD_N = 5;

    localparam logic [7:0] CMD_MAP_REGS    = 8'h00;
    localparam logic [7:0] CMD_MAP_SRAM_RO = 8'h02;
    localparam logic [7:0] CMD_MAP_SRAM_RW = 8'h03;
    localparam logic [7:0] CMD_MAP_RTC     = 8'h05;
    localparam logic [5:0] CMD_RUMBLE_HI   = 6'b001000;

    // Clock command code for strobe index (0 latch, 1 set, 2 clear ovf, 3 stop, 4 start).
    function automatic logic [7:0] rtc_cmd_code(input int idx);
        case (idx)
            0:       return 8'h10;
            1:       return 8'h11;
            2:       return 8'h14;
            3:       return 8'h18;
            default: return 8'h19;
        endcase
    endfunction

    // True when the command byte is one the mapper recognises.
    function automatic logic cmd_is_valid(input logic [7:0] c);
        case (c)
            8'h00, 8'h02, 8'h03, 8'h05,
            8'h10, 8'h11, 8'h14, 8'h18, 8'h19,
            8'h20, 8'h21, 8'h22, 8'h23: return 1'b1;
            default:                    return 1'b0;
        endcase
    endfunction

    // Clamp a requested rumble speed to the cartridge capability.
    function automatic logic [1:0] clamp_speed(input logic [1:0] req,
                                               input bit present,
                                               input bit multi);
        if (!present)
            return 2'd0;
        else if (!multi)
            return (req == 2'd0) ? 2'd0 : 2'd1;
        else
            return req;
    endfunction

endpackage

// File: rtl/mapper_bus_decode.sv
// Module: mapper_bus_decode
// Splits CPU strobes into the three address regions the mapper handles.
// Assumes a 16-bit CPU address: home area 0x0000-0x3FFF, switchable ROM
// window 0x4000-0x7FFF, external window 0xA000-0xBFFF.
module mapper_bus_decode #(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              home_wr,
    output logic              romwin_wr,
    output logic              extwin_wr,
    output logic              extwin_rd
);
    logic in_home;
    logic in_romwin;
    logic in_extwin;

    // Region match on the top address bits.
    always_comb begin
        in_home   = (addr[ADDR_W-1 -: 2] == 2'b00);
        in_romwin = (addr[ADDR_W-1 -: 2] == 2'b01);
        in_extwin = (addr[ADDR_W-1 -: 3] == 3'b101);
    end

    // Qualify region matches with the strobes.
    always_comb begin
        home_wr   = wr && in_home;
        romwin_wr = wr && in_romwin;
        extwin_wr = wr && in_extwin;
        extwin_rd = rd && in_extwin;
    end
endmodule

// File: rtl/mapper_bank_regs.sv
// Module: mapper_bank_regs
// Holds the ROM bank low/high bytes and the SRAM bank byte. Every bit that is
// written is kept. Assumes home_wr is already qualified by region.
module mapper_bank_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              home_wr,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rom_lo,
    output logic [BYTE_W-1:0] rom_hi,
    output logic [BYTE_W-1:0] sram_bank
);
    localparam logic [BYTE_W-1:0] ROM_LO_RST = BYTE_W'(1);

    // Load the byte selected by the low address bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_lo    <= ROM_LO_RST;
            rom_hi    <= '0;
            sram_bank <= '0;
        end else if (home_wr) begin
            case (reg_sel)
                2'd0:    rom_lo    <= wdata;
                2'd1:    rom_hi    <= wdata;
                2'd2:    sram_bank <= wdata;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mapper_cmd_ctrl.sv
// Module: mapper_cmd_ctrl
// Carries out command-byte writes. It sets the window mapping and the clamped
// rumble speed, raises one-cycle clock strobes, and flags unknown codes.
// Assumes cmd_wr is high for a single cycle per CPU write.
module mapper_cmd_ctrl
    import cart_mapper_pkg::*;
#(
    parameter int BYTE_W         = 8,
    parameter bit RUMBLE_PRESENT = 1'b1,
    parameter bit RUMBLE_MULTI   = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr,
    input  logic [BYTE_W-1:0]    wdata,
    output win_sel_e             win_sel,
    output logic [1:0]           rumble_speed,
    output logic [RTC_CMD_N-1:0] rtc_cmd,
    output logic                 cmd_invalid
);
    logic valid;

    // Classify the incoming command byte.
    always_comb valid = cmd_is_valid(wdata);

    // Window mapping, rumble speed and the sticky invalid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_sel      <= WIN_REGS;
            rumble_speed <= 2'd0;
            cmd_invalid  <= 1'b0;
        end else if (cmd_wr) begin
            if (!valid) begin
                cmd_invalid <= 1'b1;
            end else begin
                case (wdata)
                    CMD_MAP_REGS:    win_sel <= WIN_REGS;
                    CMD_MAP_SRAM_RO: win_sel <= WIN_SRAM_RO;
                    CMD_MAP_SRAM_RW: win_sel <= WIN_SRAM_RW;
                    CMD_MAP_RTC:     win_sel <= WIN_RTC;
                    default:         ;
                endcase
                if (wdata[7:2] == CMD_RUMBLE_HI)
                    rumble_speed <= clamp_speed(wdata[1:0], RUMBLE_PRESENT, RUMBLE_MULTI);
            end
        end
    end

    // One strobe flop per clock command code.
    for (genvar i = 0; i < RTC_CMD_N; i++) begin : g_rtc_pulse
        localparam logic [7:0] CODE = rtc_cmd_code(i);
        // Pulse for one cycle when this code is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rtc_cmd[i] <= 1'b0;
            else
                rtc_cmd[i] <= cmd_wr && (wdata == CODE);
        end
    end
endmodule

// File: rtl/mapper_readback.sv
// Module: mapper_readback
// Returns the register mirror in the external window. It answers 0xFF when no
// register read is in progress. Assumes extwin_rd is already qualified by region.
module mapper_readback
    import cart_mapper_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              extwin_rd,
    input  win_sel_e          win_sel,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] rom_lo,
    input  logic [BYTE_W-1:0] rom_hi,
    input  logic [BYTE_W-1:0] sram_bank,
    input  logic [BYTE_W-1:0] status,
    output logic [BYTE_W-1:0] rdata
);
    // Select the mirrored register or the idle value.
    always_comb begin
        rdata = '1;
        if (extwin_rd && win_sel == WIN_REGS) begin
            case (reg_sel)
                2'd0:    rdata = rom_lo;
                2'd1:    rdata = rom_hi;
                2'd2:    rdata = sram_bank;
                default: rdata = status;
            endcase
        end
    end
endmodule

// File: rtl/cart_mapper.sv
// Module: cart_mapper (top)
// Cartridge bank mapper. Decodes CPU accesses, holds the bank and command
// state, and drives the bank, window and strobe outputs. The clock, the
// memories and the motor are external. Assumes one access per strobe cycle
// and a synchronous active-low reset.
module cart_mapper
    import cart_mapper_pkg::*;
#(
    parameter int ADDR_W         = 16,
    parameter int BYTE_W         = 8,
    parameter bit RUMBLE_PRESENT = 1'b1,
    parameter bit RUMBLE_MULTI   = 1'b1,
    localparam int WIN_OFS_W     = ADDR_W - 2,
    localparam int BANK_W        = 2 * BYTE_W,
    localparam int ROM_WADDR_W   = BANK_W + WIN_OFS_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [BYTE_W-1:0]      wdata,
    input  logic                   wr,
    input  logic                   rd,
    input  logic                   rtc_running_i,
    input  logic                   rtc_ovf_i,
    output logic [BYTE_W-1:0]      rdata,
    output logic [BANK_W-1:0]      rom_bank,
    output logic                   rom_we,
    output logic [ROM_WADDR_W-1:0] rom_waddr,
    output logic [BYTE_W-1:0]      sram_bank,
    output logic                   sram_we,
    output logic                   rtc_we,
    output logic [1:0]             win_sel,
    output logic [RTC_CMD_N-1:0]   rtc_cmd,
    output logic [1:0]             rumble_speed,
    output logic                   cmd_invalid
);
    logic              home_wr, romwin_wr, extwin_wr, extwin_rd;
    logic              bank_wr, cmd_wr;
    logic [BYTE_W-1:0] rom_lo, rom_hi, status;
    win_sel_e          win_q;

    mapper_bus_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr      (addr),
        .wr        (wr),
        .rd        (rd),
        .home_wr   (home_wr),
        .romwin_wr (romwin_wr),
        .extwin_wr (extwin_wr),
        .extwin_rd (extwin_rd)
    );

    // Send home-area writes either to the bank file or to the command decoder.
    always_comb begin
        cmd_wr  = home_wr && (addr[1:0] == 2'd3);
        bank_wr = home_wr && (addr[1:0] != 2'd3);
    end

    mapper_bank_regs #(.BYTE_W(BYTE_W)) u_banks (
        .clk       (clk),
        .rst_n     (rst_n),
        .home_wr   (bank_wr),
        .reg_sel   (addr[1:0]),
        .wdata     (wdata),
        .rom_lo    (rom_lo),
        .rom_hi    (rom_hi),
        .sram_bank (sram_bank)
    );

    mapper_cmd_ctrl #(
        .BYTE_W         (BYTE_W),
        .RUMBLE_PRESENT (RUMBLE_PRESENT),
        .RUMBLE_MULTI   (RUMBLE_MULTI)
    ) u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .wdata        (wdata),
        .win_sel      (win_q),
        .rumble_speed (rumble_speed),
        .rtc_cmd      (rtc_cmd),
        .cmd_invalid  (cmd_invalid)
    );

    // Build the status byte; the unused upper bits read as ones.
    always_comb status = {{(BYTE_W-4){1'b1}}, rtc_ovf_i, rtc_running_i, rumble_speed};

    mapper_readback #(.BYTE_W(BYTE_W)) u_rdback (
        .extwin_rd (extwin_rd),
        .win_sel   (win_q),
        .reg_sel   (addr[1:0]),
        .rom_lo    (rom_lo),
        .rom_hi    (rom_hi),
        .sram_bank (sram_bank),
        .status    (status),
        .rdata     (rdata)
    );

    // Drive the bank address, the forwarded ROM write and the window enables.
    always_comb begin
        rom_bank  = {rom_hi, rom_lo};
        rom_we    = romwin_wr;
        rom_waddr = {rom_hi, rom_lo, addr[WIN_OFS_W-1:0]};
        sram_we   = extwin_wr && (win_q == WIN_SRAM_RW);
        rtc_we    = extwin_wr && (win_q == WIN_RTC);
        win_sel   = win_q;
    end
endmodule

// File: rtl/mapper_checker.sv
// Module: mapper_checker
// Checks the mapper's ports over time. It is bound into every cart_mapper
// instance. Assumes the synchronous active-low reset is asserted at time zero.
module mapper_checker #(
    parameter bit RUMBLE_PRESENT = 1'b1,
    parameter bit RUMBLE_MULTI   = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic        wr,
    input logic [15:0] rom_bank,
    input logic [7:0]  sram_bank,
    input logic [1:0]  win_sel,
    input logic        sram_we,
    input logic        rtc_we,
    input logic        rom_we,
    input logic [4:0]  rtc_cmd,
    input logic [1:0]  rumble_speed,
    input logic        cmd_invalid
);
    logic home_w, cmd_w, rom_w;
    assign home_w = wr && (addr[15:14] == 2'b00);
    assign cmd_w  = home_w && (addr[1:0] == 2'd3);
    assign rom_w  = wr && (addr[15:14] == 2'b01);

    a_r1_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (home_w && addr[1:0] == 2'd0) |=> rom_bank[7:0] == $past(wdata));
    a_r2_high_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (home_w && addr[1:0] == 2'd1) |=> rom_bank[15:8] == $past(wdata));
    a_r1_sram_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (home_w && addr[1:0] == 2'd2) |=> sram_bank == $past(wdata));
    a_r5_sram_we: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we |-> (wr && win_sel == 2'd2));
    a_r5_rtc_we: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_we |-> (wr && win_sel == 2'd3));
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rtc_cmd));
    a_r6_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (rtc_cmd != 5'd0) |-> $past(cmd_w));
    a_r6_keeps_map: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_w && wdata[7:4] == 4'h1) |=> $stable(win_sel));
    a_r7_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (!RUMBLE_PRESENT || !RUMBLE_MULTI) |-> (rumble_speed <= (RUMBLE_PRESENT ? 2'd1 : 2'd0)));
    a_r8_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rom_bank == 16'h0001 && sram_bank == 8'h00 &&
                          win_sel == 2'd0 && rumble_speed == 2'd0 && !cmd_invalid));
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_invalid |=> cmd_invalid);
    a_r10_no_bank_change: assert property (@(posedge clk) disable iff (!rst_n)
        rom_w |=> ($stable(rom_bank) && $stable(sram_bank)));
    a_r10_rom_we: assert property (@(posedge clk) disable iff (!rst_n)
        rom_we |-> rom_w);
endmodule

bind cart_mapper mapper_checker #(
    .RUMBLE_PRESENT (RUMBLE_PRESENT),
    .RUMBLE_MULTI   (RUMBLE_MULTI)
) u_mapper_checker (.*);

// File: tb/test_cart_mapper.sv
// Bench for cart_mapper: a vector table walked by one loop, then directed
// tests. A second and third instance cover the reduced rumble capabilities.
module test_cart_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_N      = 16;
    // {addr, wdata, exp rom_bank, exp sram_bank, exp win_sel, exp speed}
    localparam logic [51:0] VEC [VEC_N] = '{
        {16'h0000, 8'h34, 16'h0034, 8'h00, 2'd0, 2'd0},  // R1 low byte
        {16'h0001, 8'h12, 16'h1234, 8'h00, 2'd0, 2'd0},  // R2 high byte
        {16'h3FFE, 8'hA7, 16'h1234, 8'hA7, 2'd0, 2'd0},  // R1 SRAM bank, far alias
        {16'h1235, 8'h00, 16'h0034, 8'hA7, 2'd0, 2'd0},  // R1 alias for high byte
        {16'h2000, 8'h00, 16'h0000, 8'hA7, 2'd0, 2'd0},  // R2 bank zero kept
        {16'h0003, 8'h03, 16'h0000, 8'hA7, 2'd2, 2'd0},  // R5 SRAM rw
        {16'h0007, 8'h02, 16'h0000, 8'hA7, 2'd1, 2'd0},  // R5 SRAM ro
        {16'h000B, 8'h05, 16'h0000, 8'hA7, 2'd3, 2'd0},  // R5 clock latches
        {16'h000F, 8'h22, 16'h0000, 8'hA7, 2'd3, 2'd2},  // R7 medium
        {16'h0003, 8'h23, 16'h0000, 8'hA7, 2'd3, 2'd3},  // R7 fast
        {16'h0003, 8'h10, 16'h0000, 8'hA7, 2'd3, 2'd3},  // R6 keeps mapping
        {16'h0003, 8'h00, 16'h0000, 8'hA7, 2'd0, 2'd3},  // R5 registers
        {16'h0003, 8'h20, 16'h0000, 8'hA7, 2'd0, 2'd0},  // R7 off
        {16'h5555, 8'h99, 16'h0000, 8'hA7, 2'd0, 2'd0},  // R10 no register change
        {16'hA001, 8'h44, 16'h0000, 8'hA7, 2'd0, 2'd0},  // R5 window write ignored
        {16'h3FFF, 8'h07, 16'h0000, 8'hA7, 2'd0, 2'd0}   // R9 invalid ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic        rtc_running_i = 1'b0;
    logic        rtc_ovf_i = 1'b0;

    logic [7:0]  rdata, sram_bank;
    logic [15:0] rom_bank;
    logic        rom_we, sram_we, rtc_we, cmd_invalid;
    logic [29:0] rom_waddr;
    logic [1:0]  win_sel, rumble_speed;
    logic [4:0]  rtc_cmd;

    logic [7:0]  s_rdata, s_sram, n_rdata, n_sram;
    logic [15:0] s_rom, n_rom;
    logic        s_rwe, s_swe, s_twe, s_inv, n_rwe, n_swe, n_twe, n_inv;
    logic [29:0] s_waddr, n_waddr;
    logic [1:0]  s_win, s_spd, n_win, n_spd;
    logic [4:0]  s_cmd, n_cmd;

    int  tests = 0;
    int  fails = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cart_mapper i_cart_mapper (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rtc_running_i(rtc_running_i), .rtc_ovf_i(rtc_ovf_i), .rdata(rdata),
        .rom_bank(rom_bank), .rom_we(rom_we), .rom_waddr(rom_waddr),
        .sram_bank(sram_bank), .sram_we(sram_we), .rtc_we(rtc_we),
        .win_sel(win_sel), .rtc_cmd(rtc_cmd), .rumble_speed(rumble_speed),
        .cmd_invalid(cmd_invalid));

    cart_mapper #(.RUMBLE_MULTI(1'b0)) i_single (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rtc_running_i(rtc_running_i), .rtc_ovf_i(rtc_ovf_i), .rdata(s_rdata),
        .rom_bank(s_rom), .rom_we(s_rwe), .rom_waddr(s_waddr),
        .sram_bank(s_sram), .sram_we(s_swe), .rtc_we(s_twe),
        .win_sel(s_win), .rtc_cmd(s_cmd), .rumble_speed(s_spd),
        .cmd_invalid(s_inv));

    cart_mapper #(.RUMBLE_PRESENT(1'b0)) i_none (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rtc_running_i(rtc_running_i), .rtc_ovf_i(rtc_ovf_i), .rdata(n_rdata),
        .rom_bank(n_rom), .rom_we(n_rwe), .rom_waddr(n_waddr),
        .sram_bank(n_sram), .sram_we(n_swe), .rtc_we(n_twe),
        .win_sel(n_win), .rtc_cmd(n_cmd), .rumble_speed(n_spd),
        .cmd_invalid(n_inv));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the sampling edge.
    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    // Combinational read of the external window.
    task automatic do_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        rd = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        apply_reset();
        @(negedge clk);
        // R8 reset state
        chk("R8 rom_bank", 32'(rom_bank), 32'h0001);
        chk("R8 sram_bank", 32'(sram_bank), 32'h00);
        chk("R8 win_sel", 32'(win_sel), 32'd0);
        chk("R8 rumble", 32'(rumble_speed), 32'd0);
        chk("R8 invalid", 32'(cmd_invalid), 32'd0);
        chk("R8 rtc_cmd", 32'(rtc_cmd), 32'd0);

        // Vector table
        for (int i = 0; i < VEC_N; i++) begin
            do_write(VEC[i][51:36], VEC[i][35:28]);
            chk("R1 R2 rom_bank (table)", 32'(rom_bank), 32'(VEC[i][27:12]));
            chk("R1 sram_bank (table)", 32'(sram_bank), 32'(VEC[i][11:4]));
            chk("R5 win_sel (table)", 32'(win_sel), 32'(VEC[i][3:2]));
            chk("R7 rumble (table)", 32'(rumble_speed), 32'(VEC[i][1:0]));
        end
        // R9 flag raised by the last table entry, and it does not drop
        chk("R9 invalid set", 32'(cmd_invalid), 32'd1);
        do_write(16'h0003, 8'h00);
        chk("R9 invalid sticky", 32'(cmd_invalid), 32'd1);
        do_write(16'h0003, 8'h1F);
        chk("R9 no strobe on invalid", 32'(rtc_cmd), 32'd0);

        // R3 full 8 bits and mirror readback
        do_write(16'h0000, 8'hFE);
        do_write(16'h0001, 8'h80);
        do_write(16'h0002, 8'h81);
        do_write(16'h0003, 8'h21);
        do_read(16'hA000, rv); chk("R3 read rom low", 32'(rv), 32'hFE);
        do_read(16'hA005, rv); chk("R3 read rom high mirror", 32'(rv), 32'h80);
        do_read(16'hBFFE, rv); chk("R3 read sram bank mirror", 32'(rv), 32'h81);
        rtc_running_i = 1'b1; rtc_ovf_i = 1'b0;
        do_read(16'hA003, rv); chk("R4 status running", 32'(rv), 32'hF5);
        rtc_running_i = 1'b0; rtc_ovf_i = 1'b1;
        do_read(16'hB3F7, rv); chk("R4 status overflow", 32'(rv), 32'hF9);
        rtc_ovf_i = 1'b0;

        // R11 idle value
        @(negedge clk); addr = 16'hA000; rd = 1'b0;
        #1 chk("R11 no read strobe", 32'(rdata), 32'hFF);
        do_write(16'h0003, 8'h03);
        do_read(16'hA000, rv); chk("R11 SRAM mapped", 32'(rv), 32'hFF);

        // R5 write enables per mode
        @(negedge clk); addr = 16'hA100; wdata = 8'h5A; wr = 1'b1;
        #1 chk("R5 sram_we rw mode", 32'({sram_we, rtc_we}), 32'b10);
        @(negedge clk); wr = 1'b0;
        do_write(16'h0003, 8'h02);
        @(negedge clk); addr = 16'hA100; wr = 1'b1;
        #1 chk("R5 sram_we ro mode", 32'({sram_we, rtc_we}), 32'b00);
        @(negedge clk); wr = 1'b0;
        do_write(16'h0003, 8'h05);
        @(negedge clk); addr = 16'hBFFF; wr = 1'b1;
        #1 chk("R5 rtc_we latch mode", 32'({sram_we, rtc_we}), 32'b01);
        @(negedge clk); wr = 1'b0;

        // R6 clock strobes
        for (int k = 0; k < 5; k++) begin
            logic [7:0] code;
            case (k)
                0: code = 8'h10;
                1: code = 8'h11;
                2: code = 8'h14;
                3: code = 8'h18;
                default: code = 8'h19;
            endcase
            do_write(16'h0003, code);
            chk("R6 strobe bit", 32'(rtc_cmd), 32'(5'b00001 << k));
            chk("R6 map kept", 32'(win_sel), 32'd3);
            @(negedge clk);
            chk("R6 strobe one cycle", 32'(rtc_cmd), 32'd0);
        end

        // R7 clamping across capabilities
        do_write(16'h0003, 8'h23);
        chk("R7 multi fast", 32'(rumble_speed), 32'd3);
        chk("R7 single clamps", 32'(s_spd), 32'd1);
        chk("R7 none clamps", 32'(n_spd), 32'd0);
        do_write(16'h0003, 8'h21);
        chk("R7 single slow", 32'(s_spd), 32'd1);
        do_write(16'h0003, 8'h20);
        chk("R7 single off", 32'(s_spd), 32'd0);

        // R10 forwarded ROM write
        do_write(16'h0000, 8'h23);
        do_write(16'h0001, 8'h01);
        @(negedge clk); addr = 16'h6ABC; wdata = 8'h77; wr = 1'b1;
        #1 chk("R10 rom_we", 32'(rom_we), 32'd1);
        chk("R10 rom_waddr", 32'(rom_waddr), 32'({16'h0123, 14'h2ABC}));
        @(negedge clk); wr = 1'b0;
        chk("R10 bank unchanged", 32'(rom_bank), 32'h0123);
        #1 chk("R10 rom_we idle", 32'(rom_we), 32'd0);

        // R8 reset mid-run
        apply_reset();
        @(negedge clk);
        chk("R8 rom_bank after reset", 32'(rom_bank), 32'h0001);
        chk("R8 win and rumble after reset", 32'({win_sel, rumble_speed}), 32'd0);
        chk("R8 invalid after reset", 32'(cmd_invalid), 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule